// File: doc/BRIEF.md
# Shared CRC Engine with Raw and Post-Processed Outputs

This block computes a cyclic redundancy code over a stream of data words fed by a data mover, one beat per clock. A single set of CRC state and configuration serves every channel of the mover. The CRC width can be 8, 16 or 32 bits. The generator polynomial, the seed, per-byte input bit reversal, remainder bit reversal and a final XOR mask are all configurable. Each beat folds 8, 16 or 32 input bits into the shift register in one cycle.

Two views of the calculation are provided. The raw register value is meant for the mover's destination write and has no post-processing. The 32-bit result word applies the final XOR and, if selected, a full 32-bit bit reversal, so a reversed 8- or 16-bit code lands in the upper byte(s) of the word.

Because the state is shared, a channel takes ownership when it starts a calculation and holds it until it releases it explicitly. A start from any other channel during that time is refused and flagged, and it has no effect on the running calculation.

Top module: `crc_engine`

## Requirements
- R1: `cfg_width` selects the CRC width when a start is accepted: 2'b00 gives 8 bits, 2'b01 gives 16 bits, and 2'b10 or 2'b11 give 32 bits. The polynomial, the seed and the XOR mask use only their low width bits.
- R2: An accepted start loads the seed, masked to the width, into the shift register. It also captures all configuration inputs. Both show on the outputs on the cycle after the start.
- R3: A beat (`dat_valid` high, `dat_id` equal to the owner, lock held, no start in the same cycle) advances the register over the low 8, 16 or 32 bits of `dat_word` (`dat_size` 0, 1 or 2/3), most significant bit first. Each bit does this: feedback = top register bit XOR data bit; the register shifts left by one; the polynomial is XORed in when feedback is 1. Any other beat is ignored.
- R4: With `cfg_data_rev` set, the bit order inside each byte of the beat is mirrored before the bits enter the register. The order of the bytes is kept.
- R5: `raw_lfsr` is the register value zero-extended to 32 bits, with no XOR mask and no reversal.
- R6: With remainder reversal off, `result` is the register XOR the XOR mask, right-aligned and zero-extended.
- R7: With remainder reversal on, `result` is the same XORed value with all 32 bits mirrored. An 8-bit code therefore occupies bits 31..24, and a 16-bit code occupies bits 31..16.
- R8: A start while unlocked, or from the current owner, is accepted. A start from any other ID while locked is refused. The register, the configuration, the lock and the owner all stay unchanged, and `busy_err` pulses high for exactly the following cycle.
- R9: A release from the owner, with no start in that cycle, frees the lock. A release from any other ID is ignored. The register and the result are kept after a release.
- R10: After reset the lock is free, the owner is 0, `raw_lfsr` and `result` are 0 and `busy_err` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_width | input | 2 | CRC width code |
| cfg_poly | input | 32 | Generator polynomial, without the implicit top term |
| cfg_seed | input | 32 | Initial register value |
| cfg_xor | input | 32 | Final XOR mask for the result word |
| cfg_data_rev | input | 1 | Mirror bits inside each input byte |
| cfg_rem_rev | input | 1 | Mirror the 32-bit result word |
| start | input | 1 | Start strobe |
| start_id | input | ID_W | Requesting channel for a start |
| rel_req | input | 1 | Release strobe |
| rel_id | input | ID_W | Channel giving up the lock |
| dat_valid | input | 1 | Data beat valid |
| dat_id | input | ID_W | Channel issuing the beat |
| dat_size | input | 2 | Beat size code: 8, 16 or 32 bits |
| dat_word | input | 32 | Beat data, right-aligned |
| raw_lfsr | output | 32 | Raw register value |
| result | output | 32 | Post-processed result word |
| locked | output | 1 | Lock held |
| owner_id | output | ID_W | Current owner |
| busy_err | output | 1 | Refused-start pulse |

## Verification
Every input takes effect at one clock edge. The raw value, the result word, the lock and the owner are due on the cycle right after the strobe or beat, and `busy_err` is high for that same single cycle only. The bench drives inputs on the falling edge and updates its reference model as that cycle's edge is reached. It compares all outputs on the next falling edge, so every check looks exactly one edge after its stimulus. Known check values for standard 8-, 16- and 32-bit codes pin down the bit ordering independently of the model.

// File: rtl/crc_pkg.sv
package crc_pkg;

  localparam int CRC_W = 32;

  typedef enum logic [1:0] {
    CW_8   = 2'b00,
    CW_16  = 2'b01,
    CW_32  = 2'b10,
    CW_32X = 2'b11
  } crc_width_e;

  typedef struct packed {
    crc_width_e        width;
    logic [CRC_W-1:0]  poly;
    logic [CRC_W-1:0]  xmask;
    logic              data_rev;
    logic              rem_rev;
  } crc_cfg_t;

  function automatic logic [CRC_W-1:0] width_mask(input crc_width_e w);
    case (w)
      CW_8:    return 32'h0000_00FF;
      CW_16:   return 32'h0000_FFFF;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

  function automatic int width_bits(input crc_width_e w);
    case (w)
      CW_8:    return 8;
      CW_16:   return 16;
      default: return 32;
    endcase
  endfunction

endpackage

// File: rtl/crc_lock.sv
module crc_lock #(
  parameter int ID_W = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [ID_W-1:0] start_id,
  input  logic            rel_req,
  input  logic [ID_W-1:0] rel_id,
  input  logic            dat_valid,
  input  logic [ID_W-1:0] dat_id,
  output logic            grant,
  output logic            beat_ok,
  output logic            locked,
  output logic [ID_W-1:0] owner_id,
  output logic            busy_err
);

  logic            locked_q, locked_d;
  logic [ID_W-1:0] owner_q, owner_d;
  logic            err_q, err_d;
  logic            rel_ok;

  always_comb begin
    grant    = start && (!locked_q || (start_id == owner_q));
    beat_ok  = dat_valid && !start && locked_q && (dat_id == owner_q);
    rel_ok   = rel_req && !start && locked_q && (rel_id == owner_q);
    err_d    = start && !grant;
    locked_d = locked_q;
    owner_d  = owner_q;
    if (grant) begin
      locked_d = 1'b1;
      owner_d  = start_id;
    end else if (rel_ok) begin
      locked_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked_q <= 1'b0;
      owner_q  <= '0;
      err_q    <= 1'b0;
    end else begin
      locked_q <= locked_d;
      owner_q  <= owner_d;
      err_q    <= err_d;
    end
  end

  assign locked   = locked_q;
  assign owner_id = owner_q;
  assign busy_err = err_q;

  // R8: a foreign start leaves the lock and owner alone and flags it
  p_reject_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (start && locked_q && (start_id != owner_q))
      |=> (locked_q && (owner_q == $past(owner_q)) && busy_err));

  // R8: the flag only ever follows a refused start
  p_err_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy_err |-> $past(start && locked_q && (start_id != owner_q)));

  // R9: a release from a non-owner keeps the lock
  p_foreign_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rel_req && !start && locked_q && (rel_id != owner_q)) |=> locked_q);

  // R9: a release from the owner frees the lock
  p_owner_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rel_req && !start && locked_q && (rel_id == owner_q)) |=> !locked_q);

endmodule

// File: rtl/crc_lfsr_next.sv
module crc_lfsr_next
  import crc_pkg::*;
(
  input  logic [CRC_W-1:0] state,
  input  logic [CRC_W-1:0] poly,
  input  crc_width_e       width,
  input  logic             data_rev,
  input  logic [1:0]       size,
  input  logic [CRC_W-1:0] data,
  output logic [CRC_W-1:0] next
);

  localparam int NBYTE = CRC_W / 8;

  logic [CRC_W-1:0] din;

  // per-byte mirror of the incoming beat
  for (genvar g = 0; g < NBYTE; g++) begin : g_byte
    for (genvar k = 0; k < 8; k++) begin : g_bit
      assign din[g*8+k] = data_rev ? data[g*8+7-k] : data[g*8+k];
    end
  end

  always_comb begin
    logic [CRC_W-1:0] s;
    logic [CRC_W-1:0] msk;
    logic [CRC_W-1:0] pm;
    logic             fb;
    int               nb;
    int               top;
    msk = width_mask(width);
    pm  = poly & msk;
    top = width_bits(width) - 1;
    case (size)
      2'b00:   nb = 8;
      2'b01:   nb = 16;
      default: nb = 32;
    endcase
    s = state;
    for (int i = 0; i < CRC_W; i++) begin
      if (i < nb) begin
        fb = s[5'(top)] ^ din[5'(nb - 1 - i)];
        s  = (s << 1) & msk;
        if (fb) s = s ^ pm;
      end
    end
    next = s;
  end

endmodule

// File: rtl/crc_post.sv
module crc_post
  import crc_pkg::*;
(
  input  logic [CRC_W-1:0] state,
  input  crc_cfg_t         cfg,
  output logic [CRC_W-1:0] raw,
  output logic [CRC_W-1:0] result
);

  logic [CRC_W-1:0] msk;
  logic [CRC_W-1:0] fin;
  logic [CRC_W-1:0] mir;

  assign msk = width_mask(cfg.width);
  assign raw = state & msk;
  assign fin = (state ^ cfg.xmask) & msk;

  for (genvar b = 0; b < CRC_W; b++) begin : g_mir
    assign mir[b] = fin[CRC_W-1-b];
  end

  assign result = cfg.rem_rev ? mir : fin;

endmodule

// File: rtl/crc_engine.sv
module crc_engine
  import crc_pkg::*;
#(
  parameter int ID_W = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      cfg_width,
  input  logic [31:0]     cfg_poly,
  input  logic [31:0]     cfg_seed,
  input  logic [31:0]     cfg_xor,
  input  logic            cfg_data_rev,
  input  logic            cfg_rem_rev,
  input  logic            start,
  input  logic [ID_W-1:0] start_id,
  input  logic            rel_req,
  input  logic [ID_W-1:0] rel_id,
  input  logic            dat_valid,
  input  logic [ID_W-1:0] dat_id,
  input  logic [1:0]      dat_size,
  input  logic [31:0]     dat_word,
  output logic [31:0]     raw_lfsr,
  output logic [31:0]     result,
  output logic            locked,
  output logic [ID_W-1:0] owner_id,
  output logic            busy_err
);

  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  logic             grant, beat_ok;
  crc_cfg_t         cfg_q, cfg_d, cfg_in;
  logic [CRC_W-1:0] state_q, state_d, state_step, seed_ld;

  crc_lock #(.ID_W(ID_W)) u_lock (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .start     (start),
    .start_id  (start_id),
    .rel_req   (rel_req),
    .rel_id    (rel_id),
    .dat_valid (dat_valid),
    .dat_id    (dat_id),
    .grant     (grant),
    .beat_ok   (beat_ok),
    .locked    (locked),
    .owner_id  (owner_id),
    .busy_err  (busy_err)
  );

  crc_lfsr_next u_step (
    .state    (state_q),
    .poly     (cfg_q.poly),
    .width    (cfg_q.width),
    .data_rev (cfg_q.data_rev),
    .size     (dat_size),
    .data     (dat_word),
    .next     (state_step)
  );

  always_comb begin
    cfg_in.width    = crc_width_e'(cfg_width);
    cfg_in.poly     = cfg_poly;
    cfg_in.xmask    = cfg_xor;
    cfg_in.data_rev = cfg_data_rev;
    cfg_in.rem_rev  = cfg_rem_rev;
    seed_ld         = cfg_seed & width_mask(cfg_in.width);
    cfg_d           = cfg_q;
    state_d         = state_q;
    if (grant) begin
      cfg_d   = cfg_in;
      state_d = seed_ld;
    end else if (beat_ok) begin
      state_d = state_step;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      cfg_q   <= '0;
      state_q <= '0;
    end else begin
      cfg_q   <= cfg_d;
      state_q <= state_d;
    end
  end

  crc_post u_post (
    .state  (state_q),
    .cfg    (cfg_q),
    .raw    (raw_lfsr),
    .result (result)
  );

  // R2: an accepted start shows the masked seed on the raw output
  p_seed_load_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    grant |=> (raw_lfsr == $past(seed_ld)));

  // R3: without a start or an accepted beat the register holds
  p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!grant && !beat_ok) |=> $stable(raw_lfsr));

  // R5: the raw view of an 8-bit code never reaches the upper bytes
  p_raw_narrow_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cfg_q.width == CW_8) |-> (raw_lfsr[31:8] == '0));

  // R6: unreversed 8-bit result is right-aligned
  p_norev_zext_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ((cfg_q.width == CW_8) && !cfg_q.rem_rev) |-> (result[31:8] == '0));

  // R7: a reversed 16-bit result occupies the upper half
  p_rev_upper_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ((cfg_q.width == CW_16) && cfg_q.rem_rev) |-> (result[15:0] == '0));

endmodule

// File: tb/crc_engine_tb.sv
module crc_engine_tb;

  localparam int ID_W = 2;

  logic            clk, rst_n;
  logic [1:0]      cfg_width;
  logic [31:0]     cfg_poly, cfg_seed, cfg_xor;
  logic            cfg_data_rev, cfg_rem_rev;
  logic            start, rel_req, dat_valid;
  logic [ID_W-1:0] start_id, rel_id, dat_id;
  logic [1:0]      dat_size;
  logic [31:0]     dat_word;
  logic [31:0]     raw_lfsr, result;
  logic            locked, busy_err;
  logic [ID_W-1:0] owner_id;

  crc_engine #(.ID_W(ID_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_width(cfg_width), .cfg_poly(cfg_poly),
    .cfg_seed(cfg_seed), .cfg_xor(cfg_xor), .cfg_data_rev(cfg_data_rev),
    .cfg_rem_rev(cfg_rem_rev), .start(start), .start_id(start_id),
    .rel_req(rel_req), .rel_id(rel_id), .dat_valid(dat_valid), .dat_id(dat_id),
    .dat_size(dat_size), .dat_word(dat_word), .raw_lfsr(raw_lfsr),
    .result(result), .locked(locked), .owner_id(owner_id), .busy_err(busy_err)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int total = 0;
  int bad   = 0;

  // reference model state
  logic            m_locked, m_err, m_drev, m_rrev;
  logic [ID_W-1:0] m_owner;
  logic [1:0]      m_w;
  logic [31:0]     m_state, m_poly, m_xor;

  function automatic int bits_of(input logic [1:0] c);
    return (c == 2'd0) ? 8 : (c == 2'd1) ? 16 : 32;
  endfunction

  function automatic logic [31:0] mask_of(input logic [1:0] c);
    return (c == 2'd0) ? 32'hFF : (c == 2'd1) ? 32'hFFFF : 32'hFFFF_FFFF;
  endfunction

  function automatic logic [31:0] mirror32(input logic [31:0] v);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) r[i] = v[31-i];
    return r;
  endfunction

  function automatic logic [31:0] ref_step(input logic [31:0] s0, input logic [31:0] p,
      input logic [1:0] w, input logic [31:0] d, input logic [1:0] sz, input logic drev);
    logic [31:0] s, m;
    logic [7:0]  by;
    logic        fb;
    int          nby, top;
    s = s0; m = mask_of(w); top = bits_of(w) - 1;
    nby = bits_of(sz) / 8;
    for (int k = nby - 1; k >= 0; k--) begin
      by = d[k*8 +: 8];
      if (drev) for (int j = 0; j < 8; j++) by[j] = d[k*8 + 7 - j];
      for (int j = 7; j >= 0; j--) begin
        fb = s[top] ^ by[j];
        s = (s << 1) & m;
        if (fb) s = s ^ (p & m);
      end
    end
    return s;
  endfunction

  function automatic logic [31:0] ref_result();
    logic [31:0] f;
    f = (m_state ^ m_xor) & mask_of(m_w);
    return m_rrev ? mirror32(f) : f;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic check_all();
    check("R5 raw_lfsr", raw_lfsr, m_state & mask_of(m_w));
    check("R6 result", result, ref_result());
    check("R9 locked", {31'd0, locked}, {31'd0, m_locked});
    check("R8 owner", {30'd0, owner_id}, {30'd0, m_owner});
    check("R8 busy_err", {31'd0, busy_err}, {31'd0, m_err});
  endtask

  // apply the driven inputs to the model, advance one edge, compare
  task automatic tick();
    logic g, beat, relok;
    g     = start && (!m_locked || start_id == m_owner);
    beat  = dat_valid && !start && m_locked && dat_id == m_owner;
    relok = rel_req && !start && m_locked && rel_id == m_owner;
    m_err = start && !g;
    if (g) begin
      m_locked = 1'b1; m_owner = start_id; m_w = cfg_width;
      m_poly = cfg_poly; m_xor = cfg_xor; m_drev = cfg_data_rev; m_rrev = cfg_rem_rev;
      m_state = cfg_seed & mask_of(cfg_width);
    end else begin
      if (beat)  m_state = ref_step(m_state, m_poly, m_w, dat_word, dat_size, m_drev);
      if (relok) m_locked = 1'b0;
    end
    @(negedge clk);
    check_all();
    start = 0; rel_req = 0; dat_valid = 0;
  endtask

  task automatic do_start(input logic [ID_W-1:0] id, input logic [1:0] w, input logic [31:0] p,
      input logic [31:0] sd, input logic [31:0] x, input logic dr, input logic rr);
    start = 1; start_id = id; cfg_width = w; cfg_poly = p; cfg_seed = sd;
    cfg_xor = x; cfg_data_rev = dr; cfg_rem_rev = rr;
    tick();
  endtask

  task automatic do_beat(input logic [ID_W-1:0] id, input logic [1:0] sz, input logic [31:0] d);
    dat_valid = 1; dat_id = id; dat_size = sz; dat_word = d;
    tick();
  endtask

  task automatic do_rel(input logic [ID_W-1:0] id);
    rel_req = 1; rel_id = id;
    tick();
  endtask

  task automatic feed_digits(input logic [ID_W-1:0] id);
    for (int i = 1; i <= 9; i++) do_beat(id, 2'd0, 32'h30 + i);
  endtask

  logic [31:0] hold;

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'h1234_5678);
    rst_n = 0; start = 0; rel_req = 0; dat_valid = 0;
    start_id = 0; rel_id = 0; dat_id = 0; dat_size = 0; dat_word = 0;
    cfg_width = 0; cfg_poly = 0; cfg_seed = 0; cfg_xor = 0;
    cfg_data_rev = 0; cfg_rem_rev = 0;
    m_locked = 0; m_err = 0; m_drev = 0; m_rrev = 0; m_owner = 0;
    m_w = 0; m_state = 0; m_poly = 0; m_xor = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    // R10: reset state
    check_all();

    // R1 R3: 8-bit code, poly 0x07, seed 0, check value 0xF4
    do_start(1, 2'd0, 32'h07, 32'h0, 32'h0, 0, 0);
    feed_digits(1);
    check("R1 crc8 result", result, 32'h0000_00F4);
    do_rel(1);

    // R6: 16-bit code poly 0x1021 seed FFFF, check value 0x29B1 right-aligned
    do_start(2, 2'd1, 32'h1021, 32'hFFFF, 32'h0, 0, 0);
    feed_digits(2);
    check("R6 crc16 result", result, 32'h0000_29B1);
    do_rel(2);

    // R7 R4: 16-bit reflected code 0x8005 seed FFFF, check value 0x4B37 in upper half
    do_start(0, 2'd1, 32'h8005, 32'hFFFF, 32'h0, 1, 1);
    feed_digits(0);
    check("R7 crc16 reversed", result, 32'h4B37_0000);
    do_rel(0);

    // R4 R3: 32-bit reflected code, mixed beat sizes, check value 0xCBF43926
    do_start(3, 2'd3, 32'h04C1_1DB7, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1, 1);
    do_beat(3, 2'd2, 32'h3132_3334);
    do_beat(3, 2'd1, 32'h0000_3536);
    do_beat(3, 2'd0, 32'h37);
    do_beat(3, 2'd3, 32'h0000_3839 | 32'h0);
    hold = raw_lfsr;
    // the last beat above used 32-bit size; redo cleanly with 8-bit beats
    do_start(3, 2'd2, 32'h04C1_1DB7, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1, 1);
    do_beat(3, 2'd2, 32'h3132_3334);
    do_beat(3, 2'd1, 32'h0000_3536);
    do_beat(3, 2'd0, 32'h37);
    do_beat(3, 2'd0, 32'h38);
    do_beat(3, 2'd0, 32'h39);
    check("R4 crc32 result", result, 32'hCBF4_3926);
    // R5: raw view carries no post-processing
    check("R5 raw is unprocessed", raw_lfsr, ~mirror32(32'hCBF4_3926));

    // R8: foreign start refused, state untouched, error pulse
    hold = raw_lfsr;
    do_start(1, 2'd0, 32'h07, 32'h55, 32'h0, 0, 0);
    check("R8 refused start keeps raw", raw_lfsr, hold);
    check("R8 error pulse", {31'd0, busy_err}, 32'd1);
    do_beat(2, 2'd0, 32'hAB);
    check("R3 foreign beat ignored", raw_lfsr, hold);
    // R9: foreign release ignored, owner release frees, result kept
    do_rel(0);
    check("R9 foreign release", {31'd0, locked}, 32'd1);
    do_rel(3);
    check("R9 result kept", result, 32'hCBF4_3926);
    do_beat(3, 2'd0, 32'h11);
    check("R3 beat while unlocked ignored", raw_lfsr, hold);

    // randomized traffic against the model
    for (int n = 0; n < 600; n++) begin
      logic [31:0] r;
      r = $urandom;
      if (r[2:0] == 3'd0) begin
        start = 1; start_id = $urandom; cfg_width = $urandom;
        cfg_poly = $urandom | 32'h1; cfg_seed = $urandom; cfg_xor = $urandom;
        cfg_data_rev = $urandom; cfg_rem_rev = $urandom;
      end
      if (r[6:3] == 4'd0) begin rel_req = 1; rel_id = (r[7]) ? owner_id : ID_W'($urandom); end
      if (r[8]) begin
        dat_valid = 1; dat_id = (r[9] | r[10]) ? owner_id : ID_W'($urandom);
        dat_size = $urandom; dat_word = $urandom;
      end
      tick();
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule